// File: doc/BRIEF.md
# Two-Channel Skew-Corrected Interval Unit

This block turns pairs of timestamps from two capture channels, both counted on one shared timebase, into a channel-to-channel interval with the fixed channel offset taken out. Each pair gives a raw signed difference, computed as the second channel's stamp minus the first channel's stamp. The block then subtracts a stored skew value picked by the current temperature bin. It also reports whether that skew could be used, whether it has gone stale, and whether the temperature bin lies outside the table.

The skew table is learned on chip. Calibration is started with a pulse while both channels see one split edge. During calibration the unit adds up a power-of-two number of sample differences and tracks their smallest and largest values. It then writes the mean into the entry for the temperature bin latched at the start of calibration. The entry also records the bin as a tag, the current time as the calibration date, a version code and an allowed calibration age. The mean and the spread (largest minus smallest) are reported at the end of each calibration.

Top module: `skew_interval_unit`

## Requirements
- R1: After reset every table entry is empty. All output flags, `outValid` and `calBusy` are low, `calDone` is low, and `calMean` and `calSpread` read zero.
- R2: The raw difference is `tsB - tsA` taken modulo 2^TS_W and read as a signed two's-complement value, so a timestamp wrap gives the short signed distance. A pair with `pairValid` high while calibration is idle produces `outValid` high for exactly one cycle, on the clock edge after the pair.
- R3: When the entry for the current bin is unpopulated, `outInterval` equals the raw difference, `outUncorrected` is 1, `outExpired` is 0 and `outVersion` is 0.
- R4: A `calStart` pulse in idle with an in-range bin latches the bin, the version, the allowed age and `calLog2`. The unit then takes the next 2^calLog2 pairs as samples. It stores the sum shifted right arithmetically by `calLog2`, which rounds toward minus infinity (for example -3 and -4 give -4). Afterwards it pulses `calDone` for one cycle and shows the stored value on `calMean`.
- R5: At `calDone`, `calSpread` equals the largest sample difference minus the smallest one (0 for a single sample).
- R6: For a populated entry, `outInterval` equals the raw difference minus that entry's stored skew, with `outUncorrected` at 0. Entries for other bins are left unchanged by a calibration.
- R7: Each populated entry keeps its version code, reported on `outVersion` for corrected results, and its calibration date, which is the value of `nowTime` at the end of calibration.
- R8: `outExpired` is 1 for a corrected result exactly when `nowTime - calDate`, taken modulo 2^TIME_W, is strictly greater than the stored allowed age. An age equal to the allowed age is not expired.
- R9: A temperature bin of TEMP_BINS or above gives `outOutOfRange` = 1 and `outUncorrected` = 1, and the interval is the raw difference. A `calStart` with such a bin is ignored and `calBusy` stays low.
- R10: While `calBusy` is high, pairs are used only as calibration samples and give no `outValid`. A `calStart` seen during this time is ignored, so the version latched at the start is the one stored.
- R11: Calibrating a bin again overwrites its entry, including with a negative skew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pairValid | input | 1 | A timestamp pair is present this cycle |
| tsA | input | TS_W | First-channel timestamp |
| tsB | input | TS_W | Second-channel timestamp |
| tempBin | input | BIN_W | Current temperature bin |
| nowTime | input | TIME_W | Current time, used for calibration date and age |
| calStart | input | 1 | Pulse: start a calibration for the current bin |
| calLog2 | input | LOG_W | Log2 of the sample count for calibration |
| calVersion | input | VER_W | Version code stored with the new entry |
| calMaxAge | input | TIME_W | Allowed calibration age stored with the new entry |
| outValid | output | 1 | Result strobe |
| outInterval | output | TS_W | Skew-corrected interval, signed |
| outUncorrected | output | 1 | No usable skew entry; interval is raw |
| outExpired | output | 1 | Entry used is older than its allowed age |
| outOutOfRange | output | 1 | Temperature bin lies outside the table |
| outVersion | output | VER_W | Version of the entry used, 0 if none |
| calBusy | output | 1 | Calibration in progress |
| calDone | output | 1 | One-cycle pulse when an entry has been written |
| calMean | output | TS_W | Mean of the last calibration, signed |
| calSpread | output | TS_W | Largest minus smallest sample of the last calibration |

## Verification
The assertions assume that `calStart`, `pairValid` and `tempBin` are synchronous to `clk`. They also assume that every pair is a complete, simultaneous capture, and that the spread of calibration samples fits in TS_W bits. The bench drives all inputs on the falling edge and keeps sample differences small, so the sums never come near the accumulator width. It holds `nowTime` steady across each calibration's final cycle, so the stored date is known exactly.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef struct packed {
    logic clear;       // start of a calibration: reset accumulator, latch target
    logic accumulate;  // take the present pair as a calibration sample
    logic write;       // commit the mean into the table entry
    logic measureEn;   // pairs are measurements, not samples
  } ctl_strobe_t;

endpackage

// File: rtl/skew_control.sv
module skew_control
  import skew_pkg::*;
#(
  parameter int MAX_LOG2 = 7,
  parameter int LOG_W    = 3,
  parameter int BINS     = 6,
  parameter int BIN_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pairValid,
  input  logic             calStart,
  input  logic [LOG_W-1:0] calLog2,
  input  logic [BIN_W-1:0] tempBin,
  output ctl_strobe_t      strobe,
  output logic [LOG_W-1:0] shAmt,
  output logic             calBusy,
  output logic             calDone
);

  localparam int CNT_W = MAX_LOG2 + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_STORE} state_t;

  state_t           state;
  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [LOG_W-1:0] lgReg;
  logic [LOG_W-1:0] lgClamped;
  logic             startOk;
  logic             lastSample;

  always_comb begin
    if (int'(calLog2) > MAX_LOG2) lgClamped = LOG_W'(MAX_LOG2);
    else                          lgClamped = calLog2;
  end

  assign startOk    = (state == ST_IDLE) && calStart && (int'(tempBin) < BINS);
  assign lastIdx    = (CNT_W'(1) << lgReg) - CNT_W'(1);
  assign lastSample = (state == ST_COLLECT) && pairValid && (sampleCnt == lastIdx);

  always_comb begin
    strobe.clear      = startOk;
    strobe.accumulate = (state == ST_COLLECT) && pairValid;
    strobe.write      = (state == ST_STORE);
    strobe.measureEn  = (state == ST_IDLE);
  end

  assign shAmt   = lgReg;
  assign calBusy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleCnt <= '0;
      lgReg     <= '0;
      calDone   <= 1'b0;
    end else begin
      calDone <= (state == ST_STORE);
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            state     <= ST_COLLECT;
            sampleCnt <= '0;
            lgReg     <= lgClamped;
          end
        end
        ST_COLLECT: begin
          if (lastSample)     state     <= ST_STORE;
          else if (pairValid) sampleCnt <= sampleCnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: busy only begins from an accepted start pulse
  a_r4_start_from_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calBusy) |-> $past(calStart));

  // R4: the done pulse closes a busy period and busy has ended
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    calDone |-> ($past(calBusy) && !calBusy));

  // R9: a start for a bin outside the table never starts a calibration
  a_r9_no_start_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    (!calBusy && calStart && (int'(tempBin) >= BINS)) |=> !calBusy);

endmodule

// File: rtl/skew_datapath.sv
module skew_datapath
  import skew_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int TIME_W = 32,
  parameter int VER_W  = 8,
  parameter int BINS   = 6,
  parameter int BIN_W  = 3,
  parameter int LOG_W  = 3,
  parameter int ACC_W  = 39
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [LOG_W-1:0]  shAmt,
  input  logic              pairValid,
  input  logic [TS_W-1:0]   tsA,
  input  logic [TS_W-1:0]   tsB,
  input  logic [BIN_W-1:0]  tempBin,
  input  logic [TIME_W-1:0] nowTime,
  input  logic [VER_W-1:0]  calVersion,
  input  logic [TIME_W-1:0] calMaxAge,
  output logic              outValid,
  output logic [TS_W-1:0]   outInterval,
  output logic              outUncorrected,
  output logic              outExpired,
  output logic              outOutOfRange,
  output logic [VER_W-1:0]  outVersion,
  output logic [TS_W-1:0]   calMean,
  output logic [TS_W-1:0]   calSpread
);

  localparam int IDX_W = (BINS > 1) ? $clog2(BINS) : 1;

  // table storage
  logic              entValid [BINS];
  logic [BIN_W-1:0]  entTag   [BINS];
  logic [TS_W-1:0]   entSkew  [BINS];
  logic [TIME_W-1:0] entDate  [BINS];
  logic [VER_W-1:0]  entVer   [BINS];
  logic [TIME_W-1:0] entMaxAge[BINS];

  // calibration working state
  logic [BIN_W-1:0]         tgtBin;
  logic [VER_W-1:0]         tgtVer;
  logic [TIME_W-1:0]        tgtMaxAge;
  logic signed [ACC_W-1:0]  acc;
  logic signed [TS_W-1:0]   minDiff;
  logic signed [TS_W-1:0]   maxDiff;
  logic                     firstSample;

  logic signed [TS_W-1:0]   rawDiff;
  logic signed [ACC_W-1:0]  rawExt;
  logic signed [ACC_W-1:0]  accShifted;
  logic [TS_W-1:0]          meanVal;

  // lookup for the measurement path
  logic              inRange;
  logic [IDX_W-1:0]  selIdx;
  logic              selValid;
  logic [BIN_W-1:0]  selTag;
  logic [TS_W-1:0]   selSkew;
  logic [TIME_W-1:0] selDate;
  logic [VER_W-1:0]  selVer;
  logic [TIME_W-1:0] selMaxAge;
  logic              hit;
  logic [TIME_W-1:0] age;

  assign rawDiff    = signed'(tsB - tsA);
  assign rawExt     = {{(ACC_W-TS_W){rawDiff[TS_W-1]}}, rawDiff};
  assign accShifted = acc >>> shAmt;
  assign meanVal    = accShifted[TS_W-1:0];

  assign inRange = int'(tempBin) < BINS;
  assign selIdx  = inRange ? IDX_W'(tempBin) : '0;

  always_comb begin
    selValid  = 1'b0;
    selTag    = '0;
    selSkew   = '0;
    selDate   = '0;
    selVer    = '0;
    selMaxAge = '0;
    for (int e = 0; e < BINS; e++) begin
      if (IDX_W'(e) == selIdx) begin
        selValid  = entValid[e];
        selTag    = entTag[e];
        selSkew   = entSkew[e];
        selDate   = entDate[e];
        selVer    = entVer[e];
        selMaxAge = entMaxAge[e];
      end
    end
  end

  assign hit = inRange && selValid && (selTag == tempBin);
  assign age = nowTime - selDate;

  // one register set per table entry
  for (genvar e = 0; e < BINS; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e]  <= 1'b0;
        entTag[e]    <= '0;
        entSkew[e]   <= '0;
        entDate[e]   <= '0;
        entVer[e]    <= '0;
        entMaxAge[e] <= '0;
      end else if (strobe.write && (tgtBin == BIN_W'(e))) begin
        entValid[e]  <= 1'b1;
        entTag[e]    <= tgtBin;
        entSkew[e]   <= meanVal;
        entDate[e]   <= nowTime;
        entVer[e]    <= tgtVer;
        entMaxAge[e] <= tgtMaxAge;
      end
    end
  end

  // calibration accumulator, extremes and results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtBin      <= '0;
      tgtVer      <= '0;
      tgtMaxAge   <= '0;
      acc         <= '0;
      minDiff     <= '0;
      maxDiff     <= '0;
      firstSample <= 1'b0;
      calMean     <= '0;
      calSpread   <= '0;
    end else begin
      if (strobe.clear) begin
        tgtBin      <= tempBin;
        tgtVer      <= calVersion;
        tgtMaxAge   <= calMaxAge;
        acc         <= '0;
        firstSample <= 1'b1;
      end else if (strobe.accumulate) begin
        acc         <= acc + rawExt;
        firstSample <= 1'b0;
        if (firstSample || (rawDiff < minDiff)) minDiff <= rawDiff;
        if (firstSample || (rawDiff > maxDiff)) maxDiff <= rawDiff;
      end
      if (strobe.write) begin
        calMean   <= meanVal;
        calSpread <= maxDiff - minDiff;
      end
    end
  end

  // measurement result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      outInterval    <= '0;
      outUncorrected <= 1'b0;
      outExpired     <= 1'b0;
      outOutOfRange  <= 1'b0;
      outVersion     <= '0;
    end else begin
      outValid <= pairValid && strobe.measureEn;
      if (pairValid && strobe.measureEn) begin
        outInterval    <= hit ? (rawDiff - selSkew) : rawDiff;
        outUncorrected <= !hit;
        outExpired     <= hit && (age > selMaxAge);
        outOutOfRange  <= !inRange;
        outVersion     <= hit ? selVer : '0;
      end
    end
  end

  // R2: a result only follows a pair presented while measuring
  a_r2_result_follows_pair: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(pairValid) && $past(strobe.measureEn)));

  // R3: an uncorrected result carries the raw difference unchanged
  a_r3_raw_when_uncorrected: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUncorrected) |-> (outInterval == $past(tsB - tsA)));

  // R9: out-of-range results are never corrected
  a_r9_range_implies_raw: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOutOfRange) |-> outUncorrected);

  // R8: an uncorrected result is never reported as expired
  a_r8_expiry_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUncorrected) |-> !outExpired);

  // R10: no measurement result while samples are being collected
  a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accumulate |=> !outValid);

endmodule

// File: rtl/skew_interval_unit.sv
module skew_interval_unit
  import skew_pkg::*;
#(
  parameter int TS_W     = 32,
  parameter int TIME_W   = 32,
  parameter int VER_W    = 8,
  parameter int BINS     = 6,
  parameter int BIN_W    = 3,
  parameter int MAX_LOG2 = 7,
  parameter int LOG_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pairValid,
  input  logic [TS_W-1:0]   tsA,
  input  logic [TS_W-1:0]   tsB,
  input  logic [BIN_W-1:0]  tempBin,
  input  logic [TIME_W-1:0] nowTime,
  input  logic              calStart,
  input  logic [LOG_W-1:0]  calLog2,
  input  logic [VER_W-1:0]  calVersion,
  input  logic [TIME_W-1:0] calMaxAge,
  output logic              outValid,
  output logic [TS_W-1:0]   outInterval,
  output logic              outUncorrected,
  output logic              outExpired,
  output logic              outOutOfRange,
  output logic [VER_W-1:0]  outVersion,
  output logic              calBusy,
  output logic              calDone,
  output logic [TS_W-1:0]   calMean,
  output logic [TS_W-1:0]   calSpread
);

  localparam int ACC_W = TS_W + MAX_LOG2 + 1;

  ctl_strobe_t      strobe;
  logic [LOG_W-1:0] shAmt;

  skew_control #(
    .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W), .BINS(BINS), .BIN_W(BIN_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .calStart(calStart),
    .calLog2(calLog2), .tempBin(tempBin), .strobe(strobe), .shAmt(shAmt),
    .calBusy(calBusy), .calDone(calDone)
  );

  skew_datapath #(
    .TS_W(TS_W), .TIME_W(TIME_W), .VER_W(VER_W), .BINS(BINS),
    .BIN_W(BIN_W), .LOG_W(LOG_W), .ACC_W(ACC_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shAmt(shAmt),
    .pairValid(pairValid), .tsA(tsA), .tsB(tsB), .tempBin(tempBin),
    .nowTime(nowTime), .calVersion(calVersion), .calMaxAge(calMaxAge),
    .outValid(outValid), .outInterval(outInterval),
    .outUncorrected(outUncorrected), .outExpired(outExpired),
    .outOutOfRange(outOutOfRange), .outVersion(outVersion),
    .calMean(calMean), .calSpread(calSpread)
  );

endmodule

// File: tb/test_skew_interval_unit.sv
`timescale 1ns/1ps
module test_skew_interval_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pairValid = 1'b0;
  logic [31:0] tsA = '0, tsB = '0;
  logic [2:0]  tempBin = '0;
  logic [31:0] nowTime = '0;
  logic        calStart = 1'b0;
  logic [2:0]  calLog2 = '0;
  logic [7:0]  calVersion = '0;
  logic [31:0] calMaxAge = '0;
  logic        outValid, outUncorrected, outExpired, outOutOfRange;
  logic [31:0] outInterval, calMean, calSpread;
  logic [7:0]  outVersion;
  logic        calBusy, calDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  skew_interval_unit i_skew_interval_unit (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .tsA(tsA), .tsB(tsB),
    .tempBin(tempBin), .nowTime(nowTime), .calStart(calStart),
    .calLog2(calLog2), .calVersion(calVersion), .calMaxAge(calMaxAge),
    .outValid(outValid), .outInterval(outInterval),
    .outUncorrected(outUncorrected), .outExpired(outExpired),
    .outOutOfRange(outOutOfRange), .outVersion(outVersion),
    .calBusy(calBusy), .calDone(calDone), .calMean(calMean),
    .calSpread(calSpread)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one measurement; outputs sampled on the falling edge after the capture edge
  task automatic measure(input logic [2:0] bin, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] now);
    tempBin = bin; tsA = a; tsB = b; nowTime = now; pairValid = 1'b1;
    @(negedge clk);
    pairValid = 1'b0;
  endtask

  task automatic sample(input logic signed [31:0] d);
    tsA = 32'd5000; tsB = 32'd5000 + d; pairValid = 1'b1;
    @(negedge clk);
    pairValid = 1'b0;
  endtask

  task automatic startCal(input logic [2:0] bin, input logic [2:0] lg,
                          input logic [7:0] ver, input logic [31:0] maxAge);
    tempBin = bin; calLog2 = lg; calVersion = ver; calMaxAge = maxAge;
    calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!calDone && n < 10) begin @(negedge clk); n++; end
    check(req, "calDone", calDone, 1'b1);
  endtask

  typedef struct packed {
    logic [2:0]  bin;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] now;
    logic [31:0] expInt;
    logic        expUnc;
    logic        expExp;
    logic        expOor;
    logic [7:0]  expVer;
  } vec_t;

  // table after calibration: bin2 skew 11 ver 21 date 1000 age 100;
  // bin3 skew -4 ver 33 date 1000 age 50
  localparam vec_t VECS [9] = '{
    '{3'd2, 32'd1000, 32'd1020, 32'd1050, 32'd9,             1'b0, 1'b0, 1'b0, 8'h21},
    '{3'd2, 32'd5,    32'd0,    32'd1100, 32'hFFFF_FFF0,     1'b0, 1'b0, 1'b0, 8'h21},
    '{3'd2, 32'd0,    32'd11,   32'd1101, 32'd0,             1'b0, 1'b1, 1'b0, 8'h21},
    '{3'd3, 32'd100,  32'd90,   32'd1000, 32'hFFFF_FFFA,     1'b0, 1'b0, 1'b0, 8'h33},
    '{3'd3, 32'd0,    32'd0,    32'd1051, 32'd4,             1'b0, 1'b1, 1'b0, 8'h33},
    '{3'd1, 32'd10,   32'd17,   32'd1000, 32'd7,             1'b1, 1'b0, 1'b0, 8'h00},
    '{3'd6, 32'd0,    32'd3,    32'd1000, 32'd3,             1'b1, 1'b0, 1'b1, 8'h00},
    '{3'd7, 32'hFFFF_FFF0, 32'h10, 32'd1000, 32'd32,         1'b1, 1'b0, 1'b1, 8'h00},
    '{3'd2, 32'hFFFF_FFFE, 32'h1, 32'd1000, 32'hFFFF_FFF8,   1'b0, 1'b0, 1'b0, 8'h21}
  };

  initial begin
    #1_000_000;
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "outValid", outValid, 0);
    check("R1", "calBusy", calBusy, 0);
    check("R1", "calDone", calDone, 0);
    check("R1", "calMean", calMean, 0);
    check("R1", "calSpread", calSpread, 0);

    // R1/R3: empty table gives raw uncorrected result
    measure(3'd0, 32'd100, 32'd130, 32'd0);
    check("R2", "outValid", outValid, 1);
    check("R3", "interval", outInterval, 32'd30);
    check("R3", "uncorrected", outUncorrected, 1);
    check("R3", "version", outVersion, 0);
    @(negedge clk);
    check("R2", "single-cycle outValid", outValid, 0);

    // R4/R5 calibrate bin2 with four samples 10,12,9,13: mean 11 spread 4
    nowTime = 32'd1000;
    startCal(3'd2, 3'd2, 8'h21, 32'd100);
    check("R4", "calBusy", calBusy, 1);
    sample(10); sample(12); sample(9); sample(13);
    waitDone("R4");
    check("R4", "calMean bin2", calMean, 32'd11);
    check("R5", "calSpread bin2", calSpread, 32'd4);
    check("R4", "busy cleared", calBusy, 0);

    // R4 floor rounding: -3,-4 -> -4, spread 1
    startCal(3'd3, 3'd1, 8'h33, 32'd50);
    sample(-3); sample(-4);
    waitDone("R4");
    check("R4", "calMean floor", calMean, 32'hFFFF_FFFC);
    check("R5", "calSpread bin3", calSpread, 32'd1);

    // table-driven measurements R6 R7 R8 R9 R2
    foreach (VECS[i]) begin
      measure(VECS[i].bin, VECS[i].a, VECS[i].b, VECS[i].now);
      check("R6", $sformatf("vec%0d interval", i), outInterval, VECS[i].expInt);
      check("R3", $sformatf("vec%0d uncorrected", i), outUncorrected, VECS[i].expUnc);
      check("R8", $sformatf("vec%0d expired", i), outExpired, VECS[i].expExp);
      check("R9", $sformatf("vec%0d out of range", i), outOutOfRange, VECS[i].expOor);
      check("R7", $sformatf("vec%0d version", i), outVersion, VECS[i].expVer);
    end

    // R9: calibration start on out-of-range bin ignored
    startCal(3'd6, 3'd0, 8'h77, 32'd10);
    check("R9", "calBusy stays low", calBusy, 0);
    @(negedge clk);
    check("R9", "no calDone", calDone, 0);

    // R10/R11: recalibrate bin2 to -7; second start mid-run ignored
    nowTime = 32'd2000;
    startCal(3'd2, 3'd1, 8'h22, 32'd100);
    sample(-7);
    check("R10", "no result during cal", outValid, 0);
    startCal(3'd2, 3'd0, 8'h99, 32'd1);
    check("R10", "still busy", calBusy, 1);
    sample(-7);
    check("R10", "no result on last sample", outValid, 0);
    waitDone("R11");
    check("R11", "calMean negative", calMean, 32'hFFFF_FFF9);
    check("R5", "single-value spread", calSpread, 32'd0);
    measure(3'd2, 32'd50, 32'd50, 32'd2000);
    check("R11", "corrected by negative skew", outInterval, 32'd7);
    check("R10", "version from first start", outVersion, 8'h22);
    check("R8", "fresh entry", outExpired, 0);
    // R6: bin3 untouched by bin2 recalibration
    measure(3'd3, 32'd0, 32'd0, 32'd1000);
    check("R6", "bin3 unchanged", outInterval, 32'd4);
    check("R6", "bin3 version", outVersion, 8'h33);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule